// File: doc/BRIEF.md
# Parallel Ternary Value Sum Tree

This block adds up a parameterized number of small signed terms in one combinational pass, for example the element-wise products of two vectors whose entries are limited to -1, 0 and +1. Every lane presents its term as two flags: a "plus" flag for +1 and a "minus" flag for -1. With neither flag raised the term is zero. Raising both flags at once is an illegal code.

Lanes are first packed in groups of three into 3-bit signed partial sums. When the lane count is not a multiple of three, the last group is filled with zero terms. Partial sums are then combined in pairs, level by level, in a balanced adder tree. Each level widens its operands by one sign bit, so no level can overflow. The result is as narrow as possible while still holding both -N and +N.

A parameter selects either a combinational result or a registered result. An illegal lane adds nothing to the sum. It also sets a sticky error flag, which only the synchronous reset clears.

Top module: `tsum_tree`

## Requirements
- R1: Each lane's value is taken from its flag pair {plus, minus}: 2'b10 is +1, 2'b01 is -1 and 2'b00 is 0.
- R2: `sum_o` is the two's-complement sum of the values of all N_LANES lanes, formed in parallel.
- R3: A lane with both flags set (2'b11) adds 0 to `sum_o`.
- R4: `err_o` goes to 1 at the first rising clock edge at which any lane holds 2'b11. It stays at 1 afterwards, whatever the inputs do.
- R5: A synchronous reset sampled high clears `err_o` to 0. When the output is registered, it also clears `sum_o` to 0.
- R6: `sum_o` is $clog2(N_LANES+1)+1 bits wide. It reproduces the extremes +N_LANES (all plus) and -N_LANES (all minus) exactly.
- R7: The sum is correct when N_LANES is not a multiple of three, including N_LANES=1. The padding lanes add nothing.
- R8: With OUT_REG=1, `sum_o` shows the sum of the inputs sampled at the previous rising edge. With OUT_REG=0, `sum_o` follows the inputs in the same cycle, with no clock.
- R9: Every first-stage partial sum of three lanes lies in -3..+3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the error flag and the optional output register |
| rst | input | 1 | Synchronous reset, active high |
| plus_i | input | N_LANES | Per-lane +1 flag |
| minus_i | input | N_LANES | Per-lane -1 flag |
| sum_o | output | $clog2(N_LANES+1)+1 | Signed sum of all lanes |
| err_o | output | 1 | Sticky flag for an illegal lane code |

## Verification
With OUT_REG=0 the sum has no clock at all. The bench checks it 1 ns after the inputs change, before the next rising edge. With OUT_REG=1 the sum is due one rising edge after the inputs. The bench drives at the falling edge and samples 1 ns after the following rising edge. Just before that edge it confirms that the registered output still holds the old sum. The error flag always appears one edge after the illegal code. It is checked to be still clear before that edge, then set after it, and still set after legal inputs have returned.

// File: rtl/tsum_pkg.sv
package tsum_pkg;

  // Number of three-lane groups in the first stage.
  function automatic int groups_of(int n);
    return (n + 2) / 3;
  endfunction

  // Node count at a given tree level (level 0 = first-stage groups).
  function automatic int nodes_at(int n, int lvl);
    int c;
    c = groups_of(n);
    for (int i = 0; i < lvl; i++) c = (c + 1) / 2;
    return c;
  endfunction

  // Number of pairwise adder levels above the first stage.
  function automatic int depth_of(int n);
    int c;
    int d;
    c = groups_of(n);
    d = 0;
    for (int i = 0; i < 32; i++) begin
      if (c > 1) begin
        c = (c + 1) / 2;
        d++;
      end
    end
    return d;
  endfunction

  // Width that holds both -n and +n.
  function automatic int result_w(int n);
    return $clog2(n + 1) + 1;
  endfunction

  // Flag pair to signed value; the illegal pair maps to zero.
  function automatic logic signed [1:0] lane_value(logic p, logic m);
    case ({p, m})
      2'b10:   return 2'sb01;
      2'b01:   return 2'sb11;
      default: return 2'sb00;
    endcase
  endfunction

endpackage

// File: rtl/tsum_leaf.sv
module tsum_leaf
  import tsum_pkg::*;
(
  input  logic              [2:0] pos_i,
  input  logic              [2:0] neg_i,
  output logic signed       [2:0] part_o,
  output logic                    bad_o
);

  logic signed [2:0] v0, v1, v2;

  assign v0     = lane_value(pos_i[0], neg_i[0]);
  assign v1     = lane_value(pos_i[1], neg_i[1]);
  assign v2     = lane_value(pos_i[2], neg_i[2]);
  assign part_o = v0 + v1 + v2;
  assign bad_o  = |(pos_i & neg_i);

  // R9: a three-lane partial sum stays within -3..+3
  always_comb begin
    if (!$isunknown(part_o))
      a_r9_leaf_range: assert (part_o >= -3 && part_o <= 3);
  end

endmodule

// File: rtl/tsum_pair.sv
module tsum_pair #(
  parameter int W = 3
) (
  input  logic signed [W-1:0] a_i,
  input  logic signed [W-1:0] b_i,
  output logic signed [W:0]   s_o
);

  logic signed [W:0] a_ext, b_ext;

  assign a_ext = a_i;
  assign b_ext = b_i;
  assign s_o   = a_ext + b_ext;

endmodule

// File: rtl/tsum_tree.sv
module tsum_tree
  import tsum_pkg::*;
#(
  parameter  int N_LANES = 16,
  parameter  bit OUT_REG = 1'b1,
  localparam int RES_W   = result_w(N_LANES)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_LANES-1:0]      plus_i,
  input  logic [N_LANES-1:0]      minus_i,
  output logic signed [RES_W-1:0] sum_o,
  output logic                    err_o
);

  localparam int GROUPS = groups_of(N_LANES);
  localparam int DEPTH  = depth_of(N_LANES);
  localparam int PAD_W  = 3 * GROUPS;
  localparam int TREE_W = 3 + DEPTH;

  logic [PAD_W-1:0]        plus_pad, minus_pad;
  logic [GROUPS-1:0]       leaf_bad;
  logic                    illegal_seen;
  logic signed [TREE_W-1:0] tree_top;
  logic signed [RES_W-1:0]  sum_c;
  logic                    err_q;

  // Zero padding up to a whole number of groups.
  assign plus_pad  = PAD_W'(plus_i);
  assign minus_pad = PAD_W'(minus_i);

  for (genvar l = 0; l <= DEPTH; l++) begin : g_lvl
    localparam int CNT = nodes_at(N_LANES, l);
    logic signed [2+l:0] val [CNT];

    if (l == 0) begin : g_leaf
      for (genvar j = 0; j < CNT; j++) begin : g_j
        tsum_leaf u_leaf (
          .pos_i  (plus_pad[3*j +: 3]),
          .neg_i  (minus_pad[3*j +: 3]),
          .part_o (val[j]),
          .bad_o  (leaf_bad[j])
        );
      end
    end else begin : g_add
      localparam int PREV = nodes_at(N_LANES, l - 1);
      for (genvar j = 0; j < CNT; j++) begin : g_j
        if (2*j + 1 < PREV) begin : g_sum
          tsum_pair #(.W(2 + l)) u_pair (
            .a_i (g_lvl[l-1].val[2*j]),
            .b_i (g_lvl[l-1].val[2*j+1]),
            .s_o (val[j])
          );
        end else begin : g_pass
          assign val[j] = g_lvl[l-1].val[2*j];
        end
      end
    end
  end

  assign tree_top     = g_lvl[DEPTH].val[0];
  assign sum_c        = RES_W'(tree_top);
  assign illegal_seen = |leaf_bad;

  always_ff @(posedge clk) begin
    if (rst)               err_q <= 1'b0;
    else if (illegal_seen) err_q <= 1'b1;
  end
  assign err_o = err_q;

  if (OUT_REG) begin : g_oreg
    logic signed [RES_W-1:0] sum_q;
    always_ff @(posedge clk) begin
      if (rst) sum_q <= '0;
      else     sum_q <= sum_c;
    end
    assign sum_o = sum_q;

    // R8: registered result shows the previous cycle's tree sum
    a_r8_reg_delay: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (sum_o == $past(sum_c)));
  end else begin : g_comb
    assign sum_o = sum_c;
  end

  // R4: an illegal lane sets the flag at the next edge
  a_r4_err_set: assert property (@(posedge clk) disable iff (rst)
    illegal_seen |=> err_o);

  // R4: the flag never drops without reset
  a_r4_err_hold: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);

  // R5: reset clears the flag
  a_r5_rst_clear: assert property (@(posedge clk)
    rst |=> !err_o);

  // R6: tree output never leaves -N..+N
  a_r6_range: assert property (@(posedge clk) disable iff (rst)
    (sum_c >= -N_LANES) && (sum_c <= N_LANES));

endmodule

// File: tb/sim_tsum_tree.sv
`timescale 1ns/100ps
module sim_tsum_tree;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [15:0] p0 = '0, n0 = '0;
  logic signed [5:0] s0;
  logic e0;
  logic [0:0] p1 = '0, n1 = '0;
  logic signed [1:0] s1;
  logic e1;
  logic [4:0] p2 = '0, n2 = '0;
  logic signed [3:0] s2;
  logic e2;

  tsum_tree #(.N_LANES(16), .OUT_REG(1'b1)) u0 (
    .clk(clk), .rst(rst), .plus_i(p0), .minus_i(n0), .sum_o(s0), .err_o(e0));
  tsum_tree #(.N_LANES(1), .OUT_REG(1'b0)) u1 (
    .clk(clk), .rst(rst), .plus_i(p1), .minus_i(n1), .sum_o(s1), .err_o(e1));
  tsum_tree #(.N_LANES(5), .OUT_REG(1'b0)) u2 (
    .clk(clk), .rst(rst), .plus_i(p2), .minus_i(n2), .sum_o(s2), .err_o(e2));

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  localparam int NV = 9;
  localparam logic [15:0] VEC_P [NV] = '{16'h0000, 16'hFFFF, 16'h0000, 16'h00FF,
                                         16'h0001, 16'h0000, 16'h0F0F, 16'h1234, 16'h00F0};
  localparam logic [15:0] VEC_N [NV] = '{16'h0000, 16'h0000, 16'hFFFF, 16'hFF00,
                                         16'h0000, 16'h8000, 16'h0030, 16'h4000, 16'h0700};
  localparam int VEC_S [NV] = '{0, 16, -16, 0, 1, -1, 6, 4, 1};

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ref_sum(logic [31:0] p, logic [31:0] m, int w);
    int s = 0;
    for (int i = 0; i < w; i++) begin
      if (p[i] && !m[i]) s = s + 1;
      else if (m[i] && !p[i]) s = s - 1;
    end
    return s;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R5 reset sum u0", int'(s0), 0);
    check("R5 reset err u0", int'(e0), 0);
    check("R5 reset err u2", int'(e2), 0);
    @(negedge clk) rst = 1'b0;

    // R2 R6 table for the registered 16-lane instance
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      p0 = VEC_P[i];
      n0 = VEC_N[i];
      @(posedge clk);
      #1;
      check("R2 table sum", int'(s0), VEC_S[i]);
      check("R2 table err clear", int'(e0), 0);
    end

    // R8 registered output holds until the edge; combinational follows at once
    @(negedge clk);
    p0 = 16'h000F; n0 = 16'h0000;
    p2 = 5'b00011; n2 = 5'b00100;
    #1;
    check("R8 u0 holds old sum", int'(s0), VEC_S[NV-1]);
    check("R8 u2 same cycle", int'(s2), 1);
    @(posedge clk);
    #1;
    check("R8 u0 after edge", int'(s0), 4);

    // R1 R7 single lane encodings
    @(negedge clk); p1 = 1'b1; n1 = 1'b0; #1;
    check("R1 plus lane", int'(s1), 1);
    @(negedge clk); p1 = 1'b0; n1 = 1'b1; #1;
    check("R1 minus lane", int'(s1), -1);
    @(negedge clk); p1 = 1'b0; n1 = 1'b0; #1;
    check("R1 idle lane", int'(s1), 0);

    // R6 R7 extremes with five lanes
    @(negedge clk); p2 = 5'b11111; n2 = 5'b00000; #1;
    check("R6 u2 all plus", int'(s2), 5);
    @(negedge clk); p2 = 5'b00000; n2 = 5'b11111; #1;
    check("R6 u2 all minus", int'(s2), -5);

    // R2 R7 random legal patterns
    for (int k = 0; k < 40; k++) begin
      logic [15:0] rp, rn;
      logic [4:0]  qp, qn;
      logic        up, un;
      rp = 16'($urandom); rn = 16'($urandom) & ~rp;
      qp = 5'($urandom);  qn = 5'($urandom) & ~qp;
      up = 1'($urandom);  un = 1'($urandom) & ~up;
      @(negedge clk);
      p0 = rp; n0 = rn; p1 = up; n1 = un; p2 = qp; n2 = qn;
      #1;
      check("R7 random u1", int'(s1), ref_sum(32'(up), 32'(un), 1));
      check("R7 random u2", int'(s2), ref_sum(32'(qp), 32'(qn), 5));
      @(posedge clk);
      #1;
      check("R2 random u0", int'(s0), ref_sum(32'(rp), 32'(rn), 16));
    end

    // R3 R4 illegal lanes
    @(negedge clk);
    p2 = 5'b00111; n2 = 5'b00101;
    p1 = 1'b1;     n1 = 1'b1;
    p0 = 16'h0003; n0 = 16'h0001;
    #1;
    check("R3 u2 illegal adds zero", int'(s2), 1);
    check("R3 u1 illegal adds zero", int'(s1), 0);
    check("R4 u2 flag not before edge", int'(e2), 0);
    @(posedge clk);
    #1;
    check("R4 u2 flag set", int'(e2), 1);
    check("R4 u1 flag set", int'(e1), 1);
    check("R4 u0 flag set", int'(e0), 1);
    check("R3 u0 illegal adds zero", int'(s0), 1);
    @(negedge clk);
    p0 = '0; n0 = '0; p1 = '0; n1 = '0; p2 = '0; n2 = '0;
    repeat (2) @(posedge clk);
    #1;
    check("R4 u2 flag sticky", int'(e2), 1);
    check("R4 u0 flag sticky", int'(e0), 1);

    // R5 synchronous reset clears flag and register
    @(negedge clk); p0 = 16'h00FF; rst = 1'b1;
    @(posedge clk);
    #1;
    check("R5 err cleared u0", int'(e0), 0);
    check("R5 err cleared u2", int'(e2), 0);
    check("R5 sum cleared u0", int'(s0), 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk);
    #1;
    check("R2 after reset", int'(s0), 8);
    check("R5 flag stays clear", int'(e0), 0);

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(5 * 100000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule